// File: doc/BRIEF.md
# Floating-Point Environment Image Writer

This block keeps the environment registers of a floating-point unit and, on request, writes them to memory as a stream of 32-bit words. It holds a control word, a status word, a tag word, an instruction pointer (32-bit offset plus 16-bit selector), an operand pointer of the same shape, and an 11-bit last-opcode register. Every retired non-transparent floating-point instruction updates the pointers and the opcode register. A compatibility enable decides whether the stored opcode is always reported or only after an unmasked exception.

A request chooses one of two word layouts: protected mode or real-address mode. It also chooses between two kinds of request. An environment store emits seven words at byte offsets 0 to 24. A save-all request emits those seven words, then the eight 80-bit data registers, then returns the whole unit to its power-on defaults. The environment is copied at the moment a request is taken, so later updates cannot tear the image. The words leave through a valid/ready write port that carries a byte offset and the data. A one-cycle done pulse marks the end of the transfer.

Top module: `fenv_image_ser`

## Requirements
- R1: Reset state and defaults.
  - After reset the block is idle: `wr_valid_o`, `busy_o` and `done_o` are 0.
  - The stored state is at its defaults: control word 0x037F, status word 0x0000 and tag word 0xFFFF.
  - Both pointers, the opcode register and all data registers are zero.
- R2: Opcode recording and the compatibility enable.
  - Each cycle with `retire_i` high loads `retire_op_i` into the opcode register. Its bits 10:8 are the low three bits of the first instruction byte and bits 7:0 are the second byte.
  - The same cycle loads the four pointer fields.
  - While `compat_en_i` is 1, the image reports the recorded opcode whatever the exception flag was.
- R3: With `compat_en_i` at 0, the image opcode field carries the recorded opcode only if the last retired instruction had `retire_exc_i` high. Otherwise the field is zero.
- R4: Words at offsets 0, 4 and 8 carry the control, status and tag words in bits 15:0, with bits 31:16 zero.
- R5: Protected layout (`req_real_i`=0).
  - Offset 12 holds the instruction pointer offset.
  - Offset 16 holds {5'b0, opcode, instruction selector}.
  - Offset 20 holds the operand offset.
  - Offset 24 holds {16'b0, operand selector}.
- R6: Real-address layout (`req_real_i`=1).
  - Offset 12 holds {16'b0, ip[15:0]}.
  - Offset 16 holds {4'b0, ip[31:16], 1'b0, opcode}.
  - Offset 20 holds {16'b0, dp[15:0]}.
  - Offset 24 holds {4'b0, dp[31:16], 12'b0}.
- R7: Save-all data beats.
  - A save-all request (`req_save_all_i`=1) follows the environment with the data registers 0 to 7 in order.
  - Each register goes out as three beats at rising offsets from 28 to 120: bits 31:0, then bits 63:32, then {16'b0, bits 79:64}.
- R8: State reinitialisation.
  - Once the last save-all beat is accepted, every stored register returns to its R1 default.
  - A pulse on `init_cmd_i` does the same.
  - Either one takes priority over a same-cycle update.
- R9: Beat ordering and stalls.
  - Beats start at offset 0 and advance by 4 on each cycle with `wr_valid_o` and `wr_ready_i` both high.
  - While `wr_ready_i` is low, the offset and data hold steady.
- R10: Busy and done.
  - `busy_o` is high from the cycle after a request is accepted until the last beat is accepted.
  - `done_o` is high for exactly the one cycle after that last beat.
- R11: A request that arrives while busy is ignored: it produces no extra beats.
- R12: Snapshot protection.
  - Control, status, tag, pointer and opcode updates made during a transfer do not change the image in flight, but they do take effect for the next request.
  - Data register writes while busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| compat_en_i | input | 1 | Opcode compatibility enable |
| init_cmd_i | input | 1 | Reinitialise all state to defaults |
| ctrl_we_i | input | 1 | Control word write enable |
| ctrl_wdata_i | input | 16 | Control word write data |
| stat_we_i | input | 1 | Status word write enable |
| stat_wdata_i | input | 16 | Status word write data |
| tag_we_i | input | 1 | Tag word write enable |
| tag_wdata_i | input | 16 | Tag word write data |
| retire_i | input | 1 | A non-transparent instruction retires |
| retire_op_i | input | 11 | Opcode of the retiring instruction |
| retire_exc_i | input | 1 | Retiring instruction raised an unmasked exception |
| retire_ip_off_i | input | 32 | Instruction pointer offset |
| retire_ip_sel_i | input | 16 | Instruction pointer selector |
| retire_dp_off_i | input | 32 | Operand pointer offset |
| retire_dp_sel_i | input | 16 | Operand pointer selector |
| dreg_we_i | input | 1 | Data register write enable |
| dreg_idx_i | input | 3 | Data register index |
| dreg_wdata_i | input | 80 | Data register write value |
| req_valid_i | input | 1 | Image request |
| req_save_all_i | input | 1 | 1: save-all, 0: environment only |
| req_real_i | input | 1 | 1: real-address layout, 0: protected layout |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted |
| wr_addr_o | output | 7 | Byte offset of the beat |
| wr_data_o | output | 32 | Beat data |
| done_o | output | 1 | One-cycle pulse after the last beat |
| busy_o | output | 1 | Transfer in progress |

## Verification
Selector and offset values are distinct in every half, so a swapped field or half shows up in the packed words. Each layout is requested with default state, with populated registers, and after reinitialisation.

The opcode cases separate three conditions:
- compatibility off without an exception, which gives a zero field;
- compatibility off after an unmasked exception, which gives the opcode;
- compatibility on without an exception, which gives the opcode.

The write port is driven with three ready patterns: always ready, alternating, and a sparse pseudo-random one. These expose lost, repeated or moving beats while the port is stalled.

Updates, data writes and a second request are injected in the middle of a transfer. This separates a true snapshot from live reads, and a dropped request from one that gets queued.

// File: rtl/fenv_pkg.sv
package fenv_pkg;

  localparam int HALF_W   = 16;
  localparam int OP_W     = 11;
  localparam int OFF_W    = 32;
  localparam int IMG_W    = 32;
  localparam int ENV_WORDS = 7;
  localparam int EIDX_W   = $clog2(ENV_WORDS);

  localparam logic [HALF_W-1:0] CTRL_DFLT = 16'h037F;
  localparam logic [HALF_W-1:0] STAT_DFLT = 16'h0000;
  localparam logic [HALF_W-1:0] TAG_DFLT  = 16'hFFFF;

  typedef struct packed {
    logic [HALF_W-1:0] ctrl;
    logic [HALF_W-1:0] stat;
    logic [HALF_W-1:0] tag;
    logic [OFF_W-1:0]  ip_off;
    logic [HALF_W-1:0] ip_sel;
    logic [OFF_W-1:0]  dp_off;
    logic [HALF_W-1:0] dp_sel;
    logic [OP_W-1:0]   opcode;
  } env_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ENV  = 2'd1,
    ST_DATA = 2'd2
  } xfer_st_t;

endpackage

// File: rtl/fenv_rst_sync.sv
module fenv_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_n_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;

endmodule

// File: rtl/fenv_opcode_track.sv
module fenv_opcode_track
  import fenv_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  input  logic            compat_i,
  input  logic            retire_i,
  input  logic [OP_W-1:0] retire_op_i,
  input  logic            retire_exc_i,
  output logic [OP_W-1:0] opcode_view_o
);

  logic [OP_W-1:0] op_q, op_d;
  logic            exc_q, exc_d;
  logic            upd_en;

  assign upd_en = init_i | retire_i;

  always_comb begin
    op_d  = op_q;
    exc_d = exc_q;
    if (init_i) begin
      op_d  = '0;
      exc_d = 1'b0;
    end else if (retire_i) begin
      op_d  = retire_op_i;
      exc_d = retire_exc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= '0;
      exc_q <= 1'b0;
    end else if (upd_en) begin
      op_q  <= op_d;
      exc_q <= exc_d;
    end
  end

  // Reported only when compatibility is on or the last retire trapped
  assign opcode_view_o = (compat_i || exc_q) ? op_q : '0;

endmodule

// File: rtl/fenv_state_regs.sv
module fenv_state_regs
  import fenv_pkg::*;
#(
  parameter int NUM_DREGS = 8,
  parameter int DREG_W    = 80,
  localparam int DIDX_W   = $clog2(NUM_DREGS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               init_i,
  input  logic                               hold_i,
  input  logic                               ctrl_we_i,
  input  logic [HALF_W-1:0]                  ctrl_wdata_i,
  input  logic                               stat_we_i,
  input  logic [HALF_W-1:0]                  stat_wdata_i,
  input  logic                               tag_we_i,
  input  logic [HALF_W-1:0]                  tag_wdata_i,
  input  logic                               retire_i,
  input  logic [OFF_W-1:0]                   ip_off_i,
  input  logic [HALF_W-1:0]                  ip_sel_i,
  input  logic [OFF_W-1:0]                   dp_off_i,
  input  logic [HALF_W-1:0]                  dp_sel_i,
  input  logic                               dreg_we_i,
  input  logic [DIDX_W-1:0]                  dreg_idx_i,
  input  logic [DREG_W-1:0]                  dreg_wdata_i,
  output logic [HALF_W-1:0]                  ctrl_o,
  output logic [HALF_W-1:0]                  stat_o,
  output logic [HALF_W-1:0]                  tag_o,
  output logic [OFF_W-1:0]                   ip_off_o,
  output logic [HALF_W-1:0]                  ip_sel_o,
  output logic [OFF_W-1:0]                   dp_off_o,
  output logic [HALF_W-1:0]                  dp_sel_o,
  output logic [NUM_DREGS-1:0][DREG_W-1:0]   dregs_o
);

  logic [HALF_W-1:0] ctrl_q, ctrl_d, stat_q, stat_d, tag_q, tag_d;
  logic [OFF_W-1:0]  ip_off_q, ip_off_d, dp_off_q, dp_off_d;
  logic [HALF_W-1:0] ip_sel_q, ip_sel_d, dp_sel_q, dp_sel_d;
  logic              ctrl_en, stat_en, tag_en, ptr_en;

  assign ctrl_en = init_i | ctrl_we_i;
  assign stat_en = init_i | stat_we_i;
  assign tag_en  = init_i | tag_we_i;
  assign ptr_en  = init_i | retire_i;

  always_comb begin
    ctrl_d   = init_i ? CTRL_DFLT : ctrl_wdata_i;
    stat_d   = init_i ? STAT_DFLT : stat_wdata_i;
    tag_d    = init_i ? TAG_DFLT  : tag_wdata_i;
    ip_off_d = init_i ? '0 : ip_off_i;
    ip_sel_d = init_i ? '0 : ip_sel_i;
    dp_off_d = init_i ? '0 : dp_off_i;
    dp_sel_d = init_i ? '0 : dp_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_DFLT;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_DFLT;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= TAG_DFLT;
    end else if (tag_en) begin
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_off_q <= '0;
      ip_sel_q <= '0;
      dp_off_q <= '0;
      dp_sel_q <= '0;
    end else if (ptr_en) begin
      ip_off_q <= ip_off_d;
      ip_sel_q <= ip_sel_d;
      dp_off_q <= dp_off_d;
      dp_sel_q <= dp_sel_d;
    end
  end

  for (genvar g = 0; g < NUM_DREGS; g++) begin : g_dreg
    logic              wr_hit;
    logic              en;
    logic [DREG_W-1:0] val_q, val_d;

    assign wr_hit = dreg_we_i && !hold_i && (dreg_idx_i == DIDX_W'(g));
    assign en     = init_i | wr_hit;
    assign val_d  = init_i ? '0 : dreg_wdata_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
      end else if (en) begin
        val_q <= val_d;
      end
    end

    assign dregs_o[g] = val_q;
  end

  assign ctrl_o   = ctrl_q;
  assign stat_o   = stat_q;
  assign tag_o    = tag_q;
  assign ip_off_o = ip_off_q;
  assign ip_sel_o = ip_sel_q;
  assign dp_off_o = dp_off_q;
  assign dp_sel_o = dp_sel_q;

endmodule

// File: rtl/fenv_word_pack.sv
module fenv_word_pack
  import fenv_pkg::*;
(
  input  env_t              env_i,
  input  logic              real_i,
  input  logic [EIDX_W-1:0] idx_i,
  output logic [IMG_W-1:0]  word_o
);

  logic [IMG_W-1:0] ip_word, op_word, dp_word, ds_word;

  always_comb begin
    if (real_i) begin
      ip_word = {16'h0, env_i.ip_off[15:0]};
      op_word = {4'h0, env_i.ip_off[31:16], 1'b0, env_i.opcode};
      dp_word = {16'h0, env_i.dp_off[15:0]};
      ds_word = {4'h0, env_i.dp_off[31:16], 12'h000};
    end else begin
      ip_word = env_i.ip_off;
      op_word = {5'h00, env_i.opcode, env_i.ip_sel};
      dp_word = env_i.dp_off;
      ds_word = {16'h0, env_i.dp_sel};
    end
  end

  always_comb begin
    unique case (idx_i)
      3'd0:    word_o = {16'h0, env_i.ctrl};
      3'd1:    word_o = {16'h0, env_i.stat};
      3'd2:    word_o = {16'h0, env_i.tag};
      3'd3:    word_o = ip_word;
      3'd4:    word_o = op_word;
      3'd5:    word_o = dp_word;
      3'd6:    word_o = ds_word;
      default: word_o = '0;
    endcase
  end

endmodule

// File: rtl/fenv_image_ser.sv
module fenv_image_ser
  import fenv_pkg::*;
#(
  parameter int NUM_DREGS = 8,
  parameter int DREG_W    = 80,
  parameter int ADDR_W    = 7
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          compat_en_i,
  input  logic                          init_cmd_i,
  input  logic                          ctrl_we_i,
  input  logic [15:0]                   ctrl_wdata_i,
  input  logic                          stat_we_i,
  input  logic [15:0]                   stat_wdata_i,
  input  logic                          tag_we_i,
  input  logic [15:0]                   tag_wdata_i,
  input  logic                          retire_i,
  input  logic [10:0]                   retire_op_i,
  input  logic                          retire_exc_i,
  input  logic [31:0]                   retire_ip_off_i,
  input  logic [15:0]                   retire_ip_sel_i,
  input  logic [31:0]                   retire_dp_off_i,
  input  logic [15:0]                   retire_dp_sel_i,
  input  logic                          dreg_we_i,
  input  logic [$clog2(NUM_DREGS)-1:0]  dreg_idx_i,
  input  logic [DREG_W-1:0]             dreg_wdata_i,
  input  logic                          req_valid_i,
  input  logic                          req_save_all_i,
  input  logic                          req_real_i,
  output logic                          wr_valid_o,
  input  logic                          wr_ready_i,
  output logic [ADDR_W-1:0]             wr_addr_o,
  output logic [31:0]                   wr_data_o,
  output logic                          done_o,
  output logic                          busy_o
);

  localparam int DIDX_W        = $clog2(NUM_DREGS);
  localparam int BEATS_PER_REG = (DREG_W + IMG_W - 1) / IMG_W;
  localparam int PART_W        = (BEATS_PER_REG > 1) ? $clog2(BEATS_PER_REG) : 1;
  localparam int PAD_W         = BEATS_PER_REG * IMG_W;
  localparam logic [EIDX_W-1:0] ENV_LAST  = EIDX_W'(ENV_WORDS - 1);
  localparam logic [DIDX_W-1:0] DREG_LAST = DIDX_W'(NUM_DREGS - 1);
  localparam logic [PART_W-1:0] PART_LAST = PART_W'(BEATS_PER_REG - 1);

  logic rst_n;

  fenv_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_n_o(rst_n)
  );

  // ---------------- stored state ----------------
  logic                             init_now;
  logic                             hold_dregs;
  env_t                             live_env;
  logic [NUM_DREGS-1:0][DREG_W-1:0] dregs;

  fenv_state_regs #(
    .NUM_DREGS(NUM_DREGS),
    .DREG_W   (DREG_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .init_i      (init_now),
    .hold_i      (hold_dregs),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i),
    .stat_we_i   (stat_we_i),
    .stat_wdata_i(stat_wdata_i),
    .tag_we_i    (tag_we_i),
    .tag_wdata_i (tag_wdata_i),
    .retire_i    (retire_i),
    .ip_off_i    (retire_ip_off_i),
    .ip_sel_i    (retire_ip_sel_i),
    .dp_off_i    (retire_dp_off_i),
    .dp_sel_i    (retire_dp_sel_i),
    .dreg_we_i   (dreg_we_i),
    .dreg_idx_i  (dreg_idx_i),
    .dreg_wdata_i(dreg_wdata_i),
    .ctrl_o      (live_env.ctrl),
    .stat_o      (live_env.stat),
    .tag_o       (live_env.tag),
    .ip_off_o    (live_env.ip_off),
    .ip_sel_o    (live_env.ip_sel),
    .dp_off_o    (live_env.dp_off),
    .dp_sel_o    (live_env.dp_sel),
    .dregs_o     (dregs)
  );

  fenv_opcode_track u_op (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .init_i       (init_now),
    .compat_i     (compat_en_i),
    .retire_i     (retire_i),
    .retire_op_i  (retire_op_i),
    .retire_exc_i (retire_exc_i),
    .opcode_view_o(live_env.opcode)
  );

  // ---------------- transfer control ----------------
  xfer_st_t          st_q, st_d;
  env_t              snap_q;
  logic              snap_real_q, snap_all_q;
  logic [EIDX_W-1:0] eidx_q, eidx_d;
  logic [DIDX_W-1:0] didx_q, didx_d;
  logic [PART_W-1:0] part_q, part_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              accept, beat_hs, last_beat, cnt_en;

  assign accept  = (st_q == ST_IDLE) && req_valid_i;
  assign beat_hs = (st_q != ST_IDLE) && wr_ready_i;

  always_comb begin
    last_beat = 1'b0;
    if (beat_hs) begin
      if (st_q == ST_ENV) begin
        last_beat = (eidx_q == ENV_LAST) && !snap_all_q;
      end else if (st_q == ST_DATA) begin
        last_beat = (didx_q == DREG_LAST) && (part_q == PART_LAST);
      end
    end
  end

  assign init_now   = init_cmd_i || (last_beat && snap_all_q);
  assign hold_dregs = (st_q != ST_IDLE);
  assign cnt_en     = accept | beat_hs;

  always_comb begin
    st_d   = st_q;
    eidx_d = eidx_q;
    didx_d = didx_q;
    part_d = part_q;
    addr_d = addr_q;
    done_d = last_beat;
    if (accept) begin
      st_d   = ST_ENV;
      eidx_d = '0;
      didx_d = '0;
      part_d = '0;
      addr_d = '0;
    end else if (beat_hs) begin
      addr_d = addr_q + ADDR_W'(4);
      unique case (st_q)
        ST_ENV: begin
          if (eidx_q == ENV_LAST) begin
            st_d = snap_all_q ? ST_DATA : ST_IDLE;
          end else begin
            eidx_d = eidx_q + EIDX_W'(1);
          end
        end
        ST_DATA: begin
          if (part_q == PART_LAST) begin
            part_d = '0;
            if (didx_q == DREG_LAST) begin
              st_d = ST_IDLE;
            end else begin
              didx_d = didx_q + DIDX_W'(1);
            end
          end else begin
            part_d = part_q + PART_W'(1);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      eidx_q <= '0;
      didx_q <= '0;
      part_q <= '0;
      addr_q <= '0;
    end else if (cnt_en) begin
      eidx_q <= eidx_d;
      didx_q <= didx_d;
      part_q <= part_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      snap_q      <= '0;
      snap_real_q <= 1'b0;
      snap_all_q  <= 1'b0;
    end else if (accept) begin
      snap_q      <= live_env;
      snap_real_q <= req_real_i;
      snap_all_q  <= req_save_all_i;
    end
  end

  // ---------------- beat data ----------------
  logic [IMG_W-1:0] env_word;
  logic [PAD_W-1:0] dreg_padded;

  fenv_word_pack u_pack (
    .env_i (snap_q),
    .real_i(snap_real_q),
    .idx_i (eidx_q),
    .word_o(env_word)
  );

  assign dreg_padded = PAD_W'(dregs[didx_q]);

  assign wr_valid_o = (st_q != ST_IDLE);
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = (st_q == ST_DATA) ? dreg_padded[part_q*IMG_W +: IMG_W] : env_word;
  assign done_o     = done_q;
  assign busy_o     = (st_q != ST_IDLE);

endmodule

// File: rtl/fenv_image_ser_chk.sv
module fenv_image_ser_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              done
);

  logic env_beat;
  logic pad_beat;

  always_comb begin
    env_beat = (int'(wr_addr) <= 8);
    pad_beat = (int'(wr_addr) >= 28) && ((((int'(wr_addr) - 28) / 4) % 3) == 2);
  end

  AST_HOLD_WHILE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == ADDR_W'($past(wr_addr) + 4)))); // R9

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> (wr_addr == '0)); // R9

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((wr_addr[1:0] == 2'b00) && (int'(wr_addr) <= 120))); // R7

  AST_ENV_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && env_beat) |-> (wr_data[31:16] == 16'h0)); // R4

  AST_DATA_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && pad_beat) |-> (wr_data[31:16] == 16'h0)); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_valid && wr_ready) && !busy)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

bind fenv_image_ser fenv_image_ser_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .busy    (busy_o),
  .wr_valid(wr_valid_o),
  .wr_ready(wr_ready_i),
  .wr_addr (wr_addr_o),
  .wr_data (wr_data_o),
  .done    (done_o)
);

// File: tb/fenv_image_ser_tb_top.sv
module fenv_image_ser_tb_top;

  logic        clk;
  logic        rst_n;
  logic        compat_en, init_cmd;
  logic        ctrl_we, stat_we, tag_we;
  logic [15:0] ctrl_wd, stat_wd, tag_wd;
  logic        retire, retire_exc;
  logic [10:0] retire_op;
  logic [31:0] ip_off, dp_off;
  logic [15:0] ip_sel, dp_sel;
  logic        dreg_we;
  logic [2:0]  dreg_idx;
  logic [79:0] dreg_wd;
  logic        req_valid, req_all, req_real;
  logic        wr_valid, wr_ready, done, busy;
  logic [6:0]  wr_addr;
  logic [31:0] wr_data;

  fenv_image_ser dut_i (
    .clk_i(clk), .rst_ni(rst_n), .compat_en_i(compat_en), .init_cmd_i(init_cmd),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .stat_we_i(stat_we), .stat_wdata_i(stat_wd),
    .tag_we_i(tag_we), .tag_wdata_i(tag_wd), .retire_i(retire), .retire_op_i(retire_op),
    .retire_exc_i(retire_exc), .retire_ip_off_i(ip_off), .retire_ip_sel_i(ip_sel),
    .retire_dp_off_i(dp_off), .retire_dp_sel_i(dp_sel), .dreg_we_i(dreg_we),
    .dreg_idx_i(dreg_idx), .dreg_wdata_i(dreg_wd), .req_valid_i(req_valid),
    .req_save_all_i(req_all), .req_real_i(req_real), .wr_valid_o(wr_valid),
    .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .done_o(done), .busy_o(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct { logic [6:0] a; logic [31:0] d; string tag; } exp_t;
  exp_t q[$];

  // reference state
  logic [15:0] m_ctrl, m_stat, m_tag, m_ip_sel, m_dp_sel;
  logic [31:0] m_ip_off, m_dp_off;
  logic [10:0] m_op;
  logic        m_exc;
  logic [79:0] m_dreg [8];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_defaults();
    m_ctrl = 16'h037F; m_stat = 16'h0; m_tag = 16'hFFFF;
    m_ip_off = '0; m_ip_sel = '0; m_dp_off = '0; m_dp_sel = '0;
    m_op = '0; m_exc = 1'b0;
    for (int i = 0; i < 8; i++) m_dreg[i] = '0;
  endtask

  function automatic logic [10:0] op_view();
    return (compat_en || m_exc) ? m_op : 11'h0;
  endfunction

  task automatic push(input logic [6:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_env(input bit rl, input string op_tag, input string base_tag);
    string lt;
    lt = rl ? "R6" : "R5";
    push(7'd0, {16'h0, m_ctrl}, base_tag);
    push(7'd4, {16'h0, m_stat}, base_tag);
    push(7'd8, {16'h0, m_tag}, base_tag);
    if (rl) begin
      push(7'd12, {16'h0, m_ip_off[15:0]}, lt);
      push(7'd16, {4'h0, m_ip_off[31:16], 1'b0, op_view()}, op_tag);
      push(7'd20, {16'h0, m_dp_off[15:0]}, lt);
      push(7'd24, {4'h0, m_dp_off[31:16], 12'h0}, lt);
    end else begin
      push(7'd12, m_ip_off, lt);
      push(7'd16, {5'h0, op_view(), m_ip_sel}, op_tag);
      push(7'd20, m_dp_off, lt);
      push(7'd24, {16'h0, m_dp_sel}, lt);
    end
  endtask

  task automatic push_data(input string tag);
    for (int r = 0; r < 8; r++) begin
      push(7'(28 + r*12), m_dreg[r][31:0], tag);
      push(7'(32 + r*12), m_dreg[r][63:32], tag);
      push(7'(36 + r*12), {16'h0, m_dreg[r][79:64]}, tag);
    end
  endtask

  // ready pattern generator
  int         rdy_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  initial begin
    wr_ready = 1'b1;
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (rdy_mode)
        0: wr_ready = 1'b1;
        1: wr_ready = ~wr_ready;
        default: wr_ready = (lfsr[1:0] == 2'b00);
      endcase
    end
  end

  // monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic        prev_hs = 1'b0;
  logic [6:0]  prev_a;
  logic [31:0] prev_d;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(wr_valid && wr_addr == prev_a && wr_data == prev_d, "R9 stall hold",
              {25'h0, wr_addr, wr_data}, {25'h0, prev_a, prev_d});
      if (done)
        check(prev_hs && q.size() == 0 && !busy, "R10 done timing",
              64'(q.size()), 64'h0);
      if (wr_valid && wr_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R11 unexpected beat", {25'h0, wr_addr, wr_data}, 64'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(wr_addr == e.a && wr_data == e.d, e.tag,
                {25'h0, wr_addr, wr_data}, {25'h0, e.a, e.d});
        end
      end
      prev_stall = wr_valid && !wr_ready;
      prev_hs    = wr_valid && wr_ready;
      prev_a     = wr_addr;
      prev_d     = wr_data;
    end
  end

  task automatic issue(input bit all, input bit rl);
    @(negedge clk);
    req_valid = 1'b1; req_all = all; req_real = rl;
    @(negedge clk);
    req_valid = 1'b0; req_all = 1'b0; req_real = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", 64'(busy), 64'h1);
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R10 done seen", 64'(done), 64'h1);
    check(q.size() == 0, "R9 all beats delivered", 64'(q.size()), 64'h0);
    @(negedge clk);
  endtask

  task automatic store(input bit all, input bit rl, input string op_tag, input string base_tag);
    push_env(rl, op_tag, base_tag);
    if (all) push_data(all ? (base_tag == "R1" ? "R8" : "R7") : "R7");
    issue(all, rl);
    wait_done();
    if (all) model_defaults();
  endtask

  task automatic do_retire(input logic [10:0] op, input bit exc, input logic [31:0] io,
                           input logic [15:0] is, input logic [31:0] dpo, input logic [15:0] ds);
    @(negedge clk);
    retire = 1'b1; retire_op = op; retire_exc = exc;
    ip_off = io; ip_sel = is; dp_off = dpo; dp_sel = ds;
    @(negedge clk);
    retire = 1'b0;
    m_op = op; m_exc = exc; m_ip_off = io; m_ip_sel = is; m_dp_off = dpo; m_dp_sel = ds;
  endtask

  task automatic write_words(input logic [15:0] c, input logic [15:0] s, input logic [15:0] t);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wd = c; stat_we = 1'b1; stat_wd = s; tag_we = 1'b1; tag_wd = t;
    @(negedge clk);
    ctrl_we = 1'b0; stat_we = 1'b0; tag_we = 1'b0;
    m_ctrl = c; m_stat = s; m_tag = t;
  endtask

  task automatic write_dreg(input int idx, input logic [79:0] v, input bit expect_taken);
    @(negedge clk);
    dreg_we = 1'b1; dreg_idx = 3'(idx); dreg_wd = v;
    @(negedge clk);
    dreg_we = 1'b0;
    if (expect_taken) m_dreg[idx] = v;
  endtask

  // watchdog
  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    compat_en = 0; init_cmd = 0; ctrl_we = 0; stat_we = 0; tag_we = 0;
    ctrl_wd = 0; stat_wd = 0; tag_wd = 0; retire = 0; retire_exc = 0; retire_op = 0;
    ip_off = 0; dp_off = 0; ip_sel = 0; dp_sel = 0; dreg_we = 0; dreg_idx = 0; dreg_wd = 0;
    req_valid = 0; req_all = 0; req_real = 0;
    model_defaults();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle outputs and default image
    check(!wr_valid && !busy && !done, "R1 idle after reset",
          {61'h0, wr_valid, busy, done}, 64'h0);
    store(0, 0, "R1", "R1");

    // R3: compat off, no exception -> opcode field zero
    write_words(16'h0A7F, 16'h3800, 16'h5AA5);
    do_retire(11'h5A3, 0, 32'h89AB_CDEF, 16'h1B2C, 32'h1357_9BDF, 16'h2468);
    store(0, 0, "R3", "R4");

    // R3 with exception, real layout R6, alternating ready
    rdy_mode = 1;
    do_retire(11'h6C1, 1, 32'hFEDC_4321, 16'h0F0E, 32'h7654_A5A5, 16'h3C3C);
    store(0, 1, "R3", "R4");

    // R2: compat on, no exception -> opcode reported; sparse ready
    rdy_mode = 2;
    compat_en = 1'b1;
    do_retire(11'h7FF, 0, 32'h0102_0304, 16'hBEEF, 32'hA0B0_C0D0, 16'hCAFE);
    store(0, 0, "R2", "R4");
    store(0, 1, "R2", "R4");

    // R12: updates during a transfer do not touch the image in flight
    push_env(1, "R12", "R12");
    fork
      begin issue(0, 1); wait_done(); end
      begin
        repeat (3) @(negedge clk);
        write_words(16'h1111, 16'h2222, 16'h3333);
        do_retire(11'h155, 0, 32'h4444_5555, 16'h6666, 32'h7777_8888, 16'h9999);
      end
    join
    store(0, 0, "R12", "R12");

    // R11: a second request while busy is ignored
    push_env(0, "R11", "R11");
    fork
      begin issue(0, 0); wait_done(); end
      begin
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_all = 1'b1; req_real = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_all = 1'b0; req_real = 1'b0;
      end
    join
    repeat (6) @(negedge clk);
    check(!wr_valid && !busy, "R11 no extra transfer", {62'h0, wr_valid, busy}, 64'h0);

    // R7: save-all with populated data registers
    for (int r = 0; r < 8; r++)
      write_dreg(r, {16'(16'hC000 + r), 32'(32'h1000_0001 * (r + 3)), 32'(32'hDEAD_0000 + r * 17)}, 1);
    do_retire(11'h2B4, 1, 32'h2468_ACE0, 16'h1357, 32'h0BAD_F00D, 16'h4242);
    push_env(0, "R7", "R7");
    push_data("R7");
    fork
      begin issue(1, 0); wait_done(); end
      begin
        repeat (4) @(negedge clk);
        write_dreg(7, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, 0); // R12: dropped while busy
      end
    join
    model_defaults();

    // R8: save-all leaves defaults behind
    rdy_mode = 0;
    store(0, 0, "R8", "R8");
    store(1, 1, "R8", "R8");

    // R8: initialise command
    write_words(16'h0C7F, 16'h4100, 16'h0F0F);
    do_retire(11'h0A9, 1, 32'h5555_AAAA, 16'h1234, 32'h3333_CCCC, 16'h5678);
    write_dreg(2, 80'h1234_5678_9ABC_DEF0_1357, 1);
    @(negedge clk);
    init_cmd = 1'b1;
    @(negedge clk);
    init_cmd = 1'b0;
    model_defaults();
    store(1, 0, "R8", "R8");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R9 scoreboard drained", 64'(q.size()), 64'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule